// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

The block measures one clock against another. A reference counter runs on the selected reference clock and a test counter runs on the selected clock under test. The two counters start from programmed seeds at the same moment. When the reference counter runs out, a window counter starts on the reference clock. It counts down a third seed. The measurement passes when the test counter reaches zero while that window is still open. It fails when the test counter reaches zero before the window opens, or when the window closes before the test counter reaches zero.

Software chooses the seeds from the expected frequency ratio and an error budget. The reference seed is the window length minus the error budget. The window seed is twice the error budget. The test seed is the window length times the ratio of test to reference frequency. Both clocks are taken from a vector of candidate clock inputs.

Configuration and status use a single-cycle register port in the system clock domain. The control fields are keyed 4-bit fields. Start, completion and the counter handshake cross between the clock domains through two-flop synchronizers. In one-shot mode the block runs one measurement and then stops. In continuous mode it repeats passing measurements and stops at the first failure.

Top module: `clk_freq_cmp`

## Requirements
- R1: After reset, the status reads 0, all control bits read 0, both source selects read 0, and `done_o` and `err_o` are low.
- R2: Register address 0 holds the control register. Write bits [4f+3:4f] form key field f: f=0 is enable, f=1 is one-shot, f=2 is the error-signal enable and f=3 is the done-signal enable. The key 0xA turns a field on, 0x5 turns it off, and any other value leaves it unchanged. Reading address 0 returns field f as bit f.
- R3: Addresses 2 (reference) and 3 (test) hold the source selects. A write updates the select from bits 4:0 only when bits 15:12 equal 0xA; any other write leaves it unchanged. Reading returns the select in bits 4:0.
- R4: Addresses 4, 5 and 6 hold the reference, window and test seeds. When the test counter reaches zero while the window counter is nonzero, the status at address 1 reads 2'b10 (bit 1 is done).
- R5: When the test counter reaches zero before the reference counter has run out, only the error flag (status bit 0) is set.
- R6: When the window closes before the test counter reaches zero, only the error flag is set.
- R7: In one-shot mode each enable starts exactly one measurement. After it completes, no further flag is set until the block is disabled and enabled again.
- R8: The status flags stay set until software writes 1 to the bit. Writing 0 to a bit leaves it unchanged.
- R9: `done_o` follows the done flag and `err_o` follows the error flag only while the matching signal enable is on. The flags are recorded whatever the enables are set to.
- R10: In continuous mode the counters reload their seeds after each pass, and a new done event is reported.
- R11: In continuous mode the block stops at the first error. No flag is set after that until the block is re-enabled.
- R12: A window seed of zero always produces an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the register port |
| rst_ni | input | 1 | Active-low asynchronous reset, all domains |
| cand_clk_i | input | NUM_SRC | Candidate clocks for both counters |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| done_o | output | 1 | Done flag gated by its signal enable |
| err_o | output | 1 | Error flag gated by its signal enable |

## Verification
The assertions assume that the seeds and source selects stay unchanged while a measurement runs. They also assume that enable stays low long enough, before it is raised again, for the reference domain to see the low level. The stimulus writes the sources and seeds only while the block is disabled. After each disable it waits several reference periods before the next enable. The candidate clocks are free-running and keep a fixed ratio. The test vectors place the expected expiry at least a few hundred nanoseconds away from each edge of the window, so synchronizer latency cannot change the verdict.

// File: rtl/cfc_pkg.sv
`timescale 1ns/1ps
package cfc_pkg;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned SEL_W      = 5;
  localparam int unsigned NUM_FIELDS = 4;

  localparam logic [3:0] KEY_ON  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT     = 3'd1;
  localparam logic [ADDR_W-1:0] A_SRC_REF  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SRC_TST  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEED_REF = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEED_WIN = 3'd5;
  localparam logic [ADDR_W-1:0] A_SEED_TST = 3'd6;

  localparam int unsigned F_EN      = 0;
  localparam int unsigned F_ONESHOT = 1;
  localparam int unsigned F_ERRIE   = 2;
  localparam int unsigned F_DONEIE  = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_CNT, PH_WIN, PH_STOP} phase_e;
endpackage

// File: rtl/cfc_sync.sv
`timescale 1ns/1ps
module cfc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfc_regs.sv
`timescale 1ns/1ps
module cfc_regs
  import cfc_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  done_tgl_i,
  input  logic                  err_tgl_i,
  output logic [NUM_FIELDS-1:0] ctrl_o,
  output logic [SEL_W-1:0]      src_ref_o,
  output logic [SEL_W-1:0]      src_tst_o,
  output logic [DATA_W-1:0]     seed_ref_o,
  output logic [DATA_W-1:0]     seed_win_o,
  output logic [DATA_W-1:0]     seed_tst_o,
  output logic [1:0]            status_o,
  output logic                  done_set_o,
  output logic                  err_set_o,
  output logic                  done_o,
  output logic                  err_o
);
  logic [NUM_FIELDS-1:0] ctrl_q, ctrl_d;
  logic                  done_tgl_q, err_tgl_q;
  logic                  clr_done, clr_err;
  logic                  src_key_ok;

  assign src_key_ok = (wdata_i[15:12] == KEY_ON);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && addr_i == A_CTRL) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (wdata_i[4*f +: 4] == KEY_ON)       ctrl_d[f] = 1'b1;
        else if (wdata_i[4*f +: 4] == KEY_OFF) ctrl_d[f] = 1'b0;
      end
    end
  end

  assign clr_done   = wr_en_i && (addr_i == A_STAT) && wdata_i[1];
  assign clr_err    = wr_en_i && (addr_i == A_STAT) && wdata_i[0];
  assign done_set_o = done_tgl_i ^ done_tgl_q;
  assign err_set_o  = err_tgl_i ^ err_tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      src_ref_o  <= '0;
      src_tst_o  <= '0;
      seed_ref_o <= '0;
      seed_win_o <= '0;
      seed_tst_o <= '0;
      status_o   <= '0;
      done_tgl_q <= 1'b0;
      err_tgl_q  <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      done_tgl_q <= done_tgl_i;
      err_tgl_q  <= err_tgl_i;
      if (wr_en_i && addr_i == A_SRC_REF && src_key_ok) src_ref_o <= wdata_i[SEL_W-1:0];
      if (wr_en_i && addr_i == A_SRC_TST && src_key_ok) src_tst_o <= wdata_i[SEL_W-1:0];
      if (wr_en_i && addr_i == A_SEED_REF) seed_ref_o <= wdata_i;
      if (wr_en_i && addr_i == A_SEED_WIN) seed_win_o <= wdata_i;
      if (wr_en_i && addr_i == A_SEED_TST) seed_tst_o <= wdata_i;
      // set wins over a same-cycle clear
      status_o[1] <= done_set_o | (status_o[1] & ~clr_done);
      status_o[0] <= err_set_o  | (status_o[0] & ~clr_err);
    end
  end

  assign ctrl_o = ctrl_q;
  assign done_o = status_o[1] & ctrl_q[F_DONEIE];
  assign err_o  = status_o[0] & ctrl_q[F_ERRIE];

  always_comb begin
    case (addr_i)
      A_CTRL:     rdata_o = DATA_W'(ctrl_q);
      A_STAT:     rdata_o = DATA_W'(status_o);
      A_SRC_REF:  rdata_o = DATA_W'(src_ref_o);
      A_SRC_TST:  rdata_o = DATA_W'(src_tst_o);
      A_SEED_REF: rdata_o = seed_ref_o;
      A_SEED_WIN: rdata_o = seed_win_o;
      A_SEED_TST: rdata_o = seed_tst_o;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfc_ref_ctl.sv
`timescale 1ns/1ps
module cfc_ref_ctl
  import cfc_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             oneshot_i,
  input  logic             tz_i,
  input  logic [CNT_W-1:0] seed_ref_i,
  input  logic [CNT_W-1:0] seed_win_i,
  output logic             go_o,
  output logic             done_tgl_o,
  output logic             err_tgl_o,
  output phase_e           phase_o
);
  logic [CNT_W-1:0] ref_cnt, win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o    <= PH_IDLE;
      ref_cnt    <= '0;
      win_cnt    <= '0;
      go_o       <= 1'b0;
      done_tgl_o <= 1'b0;
      err_tgl_o  <= 1'b0;
    end else if (!run_i) begin
      phase_o <= PH_IDLE;
      go_o    <= 1'b0;
    end else begin
      case (phase_o)
        PH_IDLE: begin
          // wait for the test counter to have reloaded
          if (!tz_i) begin
            ref_cnt <= seed_ref_i;
            win_cnt <= seed_win_i;
            go_o    <= 1'b1;
            phase_o <= PH_CNT;
          end
        end
        PH_CNT: begin
          if (tz_i) begin
            err_tgl_o <= ~err_tgl_o;
            go_o      <= 1'b0;
            phase_o   <= PH_STOP;
          end else if (ref_cnt == '0) begin
            phase_o <= PH_WIN;
          end else begin
            ref_cnt <= ref_cnt - 1'b1;
          end
        end
        PH_WIN: begin
          if (win_cnt == '0) begin
            err_tgl_o <= ~err_tgl_o;
            go_o      <= 1'b0;
            phase_o   <= PH_STOP;
          end else if (tz_i) begin
            done_tgl_o <= ~done_tgl_o;
            go_o       <= 1'b0;
            phase_o    <= oneshot_i ? PH_STOP : PH_IDLE;
          end else begin
            win_cnt <= win_cnt - 1'b1;
          end
        end
        default: go_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cfc_tst_ctr.sv
`timescale 1ns/1ps
module cfc_tst_ctr #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] seed_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      zero_o <= 1'b0;
    end else if (!go_i) begin
      cnt_q  <= seed_i;
      zero_o <= 1'b0;
    end else if (cnt_q == '0) begin
      zero_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/clk_freq_cmp.sv
`timescale 1ns/1ps
module clk_freq_cmp
  import cfc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned DATA_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] cand_clk_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               done_o,
  output logic               err_o
);
  logic [NUM_FIELDS-1:0] ctrl;
  logic [SEL_W-1:0]      src_ref, src_tst;
  logic [DATA_W-1:0]     seed_ref, seed_win, seed_tst;
  logic [1:0]            status;
  logic                  done_set, err_set;
  logic                  ref_clk, tst_clk;
  logic                  run_r, oneshot_r, tz_r, go, go_t, tz;
  logic                  done_tgl, err_tgl, done_tgl_s, err_tgl_s;
  phase_e                phase;

  // out-of-range select yields a held-low clock
  function automatic logic pick_clk(input logic [NUM_SRC-1:0] c, input logic [SEL_W-1:0] s);
    pick_clk = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (s == SEL_W'(i)) pick_clk = c[i];
    end
  endfunction

  assign ref_clk = pick_clk(cand_clk_i, src_ref);
  assign tst_clk = pick_clk(cand_clk_i, src_tst);

  cfc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .done_tgl_i (done_tgl_s),
    .err_tgl_i  (err_tgl_s),
    .ctrl_o     (ctrl),
    .src_ref_o  (src_ref),
    .src_tst_o  (src_tst),
    .seed_ref_o (seed_ref),
    .seed_win_o (seed_win),
    .seed_tst_o (seed_tst),
    .status_o   (status),
    .done_set_o (done_set),
    .err_set_o  (err_set),
    .done_o, .err_o
  );

  cfc_sync #(.W(2)) u_sync_cfg (
    .clk_i (ref_clk), .rst_ni,
    .d_i   ({ctrl[F_ONESHOT], ctrl[F_EN]}),
    .q_o   ({oneshot_r, run_r})
  );

  cfc_sync #(.W(1)) u_sync_tz (
    .clk_i (ref_clk), .rst_ni, .d_i (tz), .q_o (tz_r)
  );

  cfc_ref_ctl #(.CNT_W(DATA_W)) u_ref (
    .clk_i      (ref_clk),
    .rst_ni,
    .run_i      (run_r),
    .oneshot_i  (oneshot_r),
    .tz_i       (tz_r),
    .seed_ref_i (seed_ref),
    .seed_win_i (seed_win),
    .go_o       (go),
    .done_tgl_o (done_tgl),
    .err_tgl_o  (err_tgl),
    .phase_o    (phase)
  );

  cfc_sync #(.W(1)) u_sync_go (
    .clk_i (tst_clk), .rst_ni, .d_i (go), .q_o (go_t)
  );

  cfc_tst_ctr #(.CNT_W(DATA_W)) u_tst (
    .clk_i  (tst_clk),
    .rst_ni,
    .go_i   (go_t),
    .seed_i (seed_tst),
    .zero_o (tz)
  );

  cfc_sync #(.W(2)) u_sync_res (
    .clk_i (clk_i), .rst_ni,
    .d_i   ({done_tgl, err_tgl}),
    .q_o   ({done_tgl_s, err_tgl_s})
  );
endmodule

// File: rtl/cfc_checker.sv
`timescale 1ns/1ps
module cfc_checker
  import cfc_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [NUM_FIELDS-1:0] ctrl,
  input logic [SEL_W-1:0]      src_ref,
  input logic [SEL_W-1:0]      src_tst,
  input logic [1:0]            status,
  input logic                  done_set,
  input logic                  ref_clk,
  input phase_e                phase,
  input logic                  done_tgl,
  input logic                  err_tgl
);
  a_r2_bad_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL && wdata_i[15:12] != KEY_ON && wdata_i[15:12] != KEY_OFF)
    |=> $stable(ctrl[F_DONEIE]))
    else $error("a_r2_bad_key_hold");

  a_r3_src_nokey: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_SRC_REF || addr_i == A_SRC_TST) && wdata_i[15:12] != KEY_ON)
    |=> ($stable(src_ref) && $stable(src_tst)))
    else $error("a_r3_src_nokey");

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[1] && !(wr_en_i && addr_i == A_STAT && wdata_i[1])) |=> status[1])
    else $error("a_r8_done_sticky");

  a_r8_w1c_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_STAT && wdata_i[1] && !done_set) |=> !status[1])
    else $error("a_r8_w1c_done");

  a_r5_no_done_before_window: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    (phase == PH_CNT) |=> $stable(done_tgl))
    else $error("a_r5_no_done_before_window");

  a_r7_stop_quiet: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    (phase == PH_STOP) |=> ($stable(done_tgl) && $stable(err_tgl)))
    else $error("a_r7_stop_quiet");
endmodule

bind clk_freq_cmp cfc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .ctrl, .src_ref, .src_tst, .status, .done_set,
  .ref_clk, .phase, .done_tgl, .err_tgl
);

// File: tb/clk_freq_cmp_bench.sv
`timescale 1ns/1ps
module clk_freq_cmp_bench;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned NV     = 8;
  localparam int TREF = 40;
  // {test source, reference seed, window seed, test seed}
  localparam int VT [NV][4] = '{
    '{1, 90, 20, 200}, '{1, 90, 20, 100}, '{1, 90, 20, 400}, '{3, 90, 30, 49},
    '{2, 90, 20, 100}, '{2, 90, 20, 70},  '{2, 90, 0, 90},   '{1, 40, 14, 85}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
  logic [3:0] cand;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic done_o, err_o;
  int checks = 0, fails = 0;
  logic [DATA_W-1:0] d;

  always #10 clk = ~clk;
  always #20 c0 = ~c0;
  always #10 c1 = ~c1;
  initial begin #7; forever #20 c2 = ~c2; end
  always #40 c3 = ~c3;
  assign cand = {c3, c2, c1, c0};

  clk_freq_cmp #(.NUM_SRC(4), .DATA_W(DATA_W)) u_clk_freq_cmp (
    .clk_i(clk), .rst_ni(rst_n), .cand_clk_i(cand), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk); addr = a; #2; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(output logic [DATA_W-1:0] v);
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, v);
      if (v[1:0] != 2'b00) break;
    end
  endtask

  function automatic int tper(input int s);
    case (s)
      1: tper = 20;
      3: tper = 80;
      default: tper = 40;
    endcase
  endfunction

  // nominal expiry time plus synchronizer latency, against the window edges
  function automatic logic [1:0] expect_st(input int s, input int s0, input int sv, input int s1);
    int t, open_t, close_t;
    t       = (s1 + 1) * tper(s) + 3 * tper(s) + 3 * TREF;
    open_t  = (s0 + 1) * TREF;
    close_t = (s0 + sv + 1) * TREF;
    if (sv == 0 || t < open_t || t > close_t) expect_st = 2'b01;
    else expect_st = 2'b10;
  endfunction

  task automatic setup(input int s, input int s0, input int sv, input int s1, input bit one);
    wr(3'd2, 24'h00A000);
    wr(3'd3, 24'h00A000 | DATA_W'(s));
    wr(3'd4, DATA_W'(s0));
    wr(3'd5, DATA_W'(sv));
    wr(3'd6, DATA_W'(s1));
    wr(3'd0, one ? 24'h0000AA : 24'h00005A);
  endtask

  task automatic stop_and_clear();
    wr(3'd0, 24'h000005);
    idle(30);
    wr(3'd1, 24'h000003);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    rd(3'd1, d); chk(d == 0, "R1 status", int'(d), 0);
    rd(3'd0, d); chk(d == 0, "R1 ctrl", int'(d), 0);
    rd(3'd3, d); chk(d == 0, "R1 src", int'(d), 0);
    chk(!done_o && !err_o, "R1 outputs", int'({done_o, err_o}), 0);

    // R2 keyed fields
    wr(3'd0, 24'h00A000); rd(3'd0, d); chk(d == 24'h8, "R2 key on", int'(d), 8);
    wr(3'd0, 24'h007000); rd(3'd0, d); chk(d == 24'h8, "R2 bad key", int'(d), 8);
    wr(3'd0, 24'h005000); rd(3'd0, d); chk(d == 24'h0, "R2 key off", int'(d), 0);

    // R3 keyed source select
    wr(3'd3, 24'h00A002); rd(3'd3, d); chk(d == 2, "R3 keyed", int'(d), 2);
    wr(3'd3, 24'h005001); rd(3'd3, d); chk(d == 2, "R3 no key", int'(d), 2);
    wr(3'd3, 24'h00A001); rd(3'd3, d); chk(d == 1, "R3 rekey", int'(d), 1);

    // table of one-shot measurements: R4 pass, R5 early, R6 late, R12 zero window
    for (int v = 0; v < NV; v++) begin
      logic [1:0] e;
      e = expect_st(VT[v][0], VT[v][1], VT[v][2], VT[v][3]);
      setup(VT[v][0], VT[v][1], VT[v][2], VT[v][3], 1'b1);
      wait_flag(d);
      if (e == 2'b10)         chk(d[1:0] == e, "R4 pass", int'(d), int'(e));
      else if (VT[v][2] == 0) chk(d[1:0] == e, "R12 zero window", int'(d), int'(e));
      else if (VT[v][3] < 150 && VT[v][0] != 3) chk(d[1:0] == e, "R5 early", int'(d), int'(e));
      else                    chk(d[1:0] == e, "R6 late", int'(d), int'(e));
      if (v == 0) begin
        chk(!done_o, "R9 done gated", int'(done_o), 0);
        wr(3'd0, 24'h00A000); @(negedge clk);
        chk(done_o, "R9 done enabled", int'(done_o), 1);
        wr(3'd0, 24'h005000);
        wr(3'd1, 24'h000001); rd(3'd1, d); chk(d == 2, "R8 w0 keeps", int'(d), 2);
        wr(3'd1, 24'h000002); rd(3'd1, d); chk(d == 0, "R8 w1 clears", int'(d), 0);
        idle(400); rd(3'd1, d); chk(d == 0, "R7 one-shot stops", int'(d), 0);
      end
      if (v == 1) begin
        chk(!err_o, "R9 err gated", int'(err_o), 0);
        wr(3'd0, 24'h000A00); @(negedge clk);
        chk(err_o, "R9 err enabled", int'(err_o), 1);
        wr(3'd0, 24'h000500);
      end
      stop_and_clear();
    end

    // R10 continuous reload
    setup(VT[0][0], VT[0][1], VT[0][2], VT[0][3], 1'b0);
    wait_flag(d); chk(d[1:0] == 2'b10, "R10 first pass", int'(d), 2);
    wr(3'd1, 24'h000003);
    wait_flag(d); chk(d[1:0] == 2'b10, "R10 repeat pass", int'(d), 2);
    stop_and_clear();

    // R11 continuous stops on error
    setup(VT[1][0], VT[1][1], VT[1][2], VT[1][3], 1'b0);
    wait_flag(d); chk(d[1:0] == 2'b01, "R11 error", int'(d), 1);
    wr(3'd1, 24'h000003);
    idle(600); rd(3'd1, d); chk(d == 0, "R11 halted", int'(d), 0);
    stop_and_clear();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule